// File: doc/BRIEF.md
# Touch-panel ADC command sequencer

This block turns one command byte from a serial host link into the control sequence of a touch-panel converter. The 4-bit channel code picks what is measured. For chip temperature, battery level and the auxiliary inputs, it selects the analog source and switches on that source's bias or divider. For a position or pressure reading, it turns on the resistive panel drivers and selects the differential reference. The power field sets what stays powered after the command. The width bit picks 12-bit or 8-bit resolution.

Serial-bus events frame the sample window. Acquisition opens on the clock fall that follows the last channel bit. It closes on the STOP or repeated START that ends the transfer, and conversion begins at once. The successive-approximation register tries one bit per clock against a comparator input, latches the result and pulses a done strobe. Three codes only switch panel drivers so that the panel can settle before a later measurement command.

Top module: `conv_sequencer`

## Requirements
- R1: The command byte is read as bits [7:4] channel code, bits [3:2] power field, bit [1] width select (1 = 8-bit, 0 = 12-bit); bit [0] has no effect on any output.
- R2: Codes 0000, 0100, 0001, 0101, 0010 and 0110 use the single-ended reference (ref_diff_o = 0) and, only while acquiring, assert mux_en_o with mux_sel_o = 0, 1, 2, 3, 4, 5 respectively (diode 0, diode 1, battery 1, battery 2, aux 1, aux 2).
- R3: Code 1100 drives {yp,ym} and samples X+ (mux_sel_o = 6); code 1101 drives {xp,xm} and samples Y+ (7); code 1110 drives {yp,xm} and samples X+ (6); code 1111 drives {yp,xm} and samples Y- (8). All codes with bit 3 set use the differential reference. drv_o is ordered {xp,xm,yp,ym}.
- R4: Codes 1000, 1001 and 1010 assert drivers {xp,xm}, {yp,ym} and {yp,xm} from the acquisition start, never assert mux_en_o or done_o, and keep the drivers on after the bus end until the next command byte is taken.
- R5: Reserved codes 0011, 0111 and 1011 switch on no driver, no mux input and no conversion.
- R6: Acquisition runs from the chan_edge_i strobe to the bus_end_i strobe. Conversion starts on the next clock. mux_en_o is low during conversion, and panel drivers of a position code stay on until the result is out.
- R7: bias_lo_o (code 0000), bias_hi_o (code 0100, the 91x bias), bat_div_o[0] (code 0001) and bat_div_o[1] (code 0101) are high only while their own channel is being acquired; at most one of them is high.
- R8: ref_on_o takes the power field's bit 3 and the idle adc_on_o takes bit 2. Both are updated only on bus_end_i. adc_on_o is also high throughout acquisition and conversion. Both are 0 after reset.
- R9: After a conversion, the position drivers stay on if power bit 2 is 1 and are released if it is 0; loading a new command releases held drivers.
- R10: The result is the binary search of the comparator input, MSB first. In 12-bit mode done_o rises 12 cycles after the clock that samples bus_end_i. In 8-bit mode it rises 8 cycles after and the result is right-aligned with bits [11:8] zero.
- R11: done_o is a single-cycle pulse.
- R12: A command byte received during acquisition or conversion does not disturb the running measurement; it is taken as the next command once the result has been produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_byte_i | input | 8 | Command byte |
| chan_edge_i | input | 1 | Serial clock fall after the last channel bit |
| bus_end_i | input | 1 | STOP or repeated START ending the command |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial level |
| mux_en_o | output | 1 | Analog input connected to the sampler |
| mux_sel_o | output | 4 | Selected source (15 when none) |
| drv_o | output | 4 | Panel drivers {xp,xm,yp,ym} |
| bias_lo_o | output | 1 | Diode bias, unit current |
| bias_hi_o | output | 1 | Diode bias, 91x current |
| bat_div_o | output | 2 | Battery dividers {bat2,bat1} |
| ref_diff_o | output | 1 | Differential (ratiometric) reference selected |
| ref_on_o | output | 1 | Internal reference powered |
| adc_on_o | output | 1 | Converter powered |
| trial_o | output | 12 | Trial code presented to the DAC |
| result_o | output | 12 | Conversion result |
| done_o | output | 1 | Result valid strobe |

## Verification
The enables and the mux select depend on the command register and the sequencing state. They are therefore sampled on the falling edge after the registering rising edge of cmd_valid_i, chan_edge_i or bus_end_i. For each conversion, the driver task records in a scoreboard entry the value the bench computes and the cycle at which done_o must appear: 12 or 8 clocks after the edge that took bus_end_i. The monitor compares both value and cycle. The comparator is modelled by comparing trial_o with a bench-held level.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned DRV_W  = 4;

  localparam logic [SEL_W-1:0] SEL_DIODE0 = 4'd0;
  localparam logic [SEL_W-1:0] SEL_DIODE1 = 4'd1;
  localparam logic [SEL_W-1:0] SEL_BAT1   = 4'd2;
  localparam logic [SEL_W-1:0] SEL_BAT2   = 4'd3;
  localparam logic [SEL_W-1:0] SEL_AUX1   = 4'd4;
  localparam logic [SEL_W-1:0] SEL_AUX2   = 4'd5;
  localparam logic [SEL_W-1:0] SEL_XP     = 4'd6;
  localparam logic [SEL_W-1:0] SEL_YP     = 4'd7;
  localparam logic [SEL_W-1:0] SEL_YM     = 4'd8;
  localparam logic [SEL_W-1:0] SEL_NONE   = 4'd15;

  // drv bit order {xp, xm, yp, ym}
  localparam logic [DRV_W-1:0] DRV_X  = 4'b1100;
  localparam logic [DRV_W-1:0] DRV_Y  = 4'b0011;
  localparam logic [DRV_W-1:0] DRV_YX = 4'b0110;

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_ACQ, ST_CONV} seq_state_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [1:0]        pwr;
    logic              short_res;
  } cmd_t;

  typedef struct packed {
    logic              conv;
    logic              diff;
    logic [DRV_W-1:0]  drv;
    logic [SEL_W-1:0]  sel;
    logic              bias_lo;
    logic              bias_hi;
    logic [1:0]        bat;
  } route_t;

  function automatic cmd_t unpack_cmd(input logic [7:0] b);
    cmd_t c;
    c.code      = b[7:4];
    c.pwr       = b[3:2];
    c.short_res = b[1];
    return c;
  endfunction
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import conv_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output route_t            route_o
);
  always_comb begin
    route_o      = '0;
    route_o.sel  = SEL_NONE;
    route_o.diff = code_i[3];
    unique case (code_i)
      4'b0000: begin route_o.conv = 1'b1; route_o.sel = SEL_DIODE0; route_o.bias_lo = 1'b1; end
      4'b0100: begin route_o.conv = 1'b1; route_o.sel = SEL_DIODE1; route_o.bias_hi = 1'b1; end
      4'b0001: begin route_o.conv = 1'b1; route_o.sel = SEL_BAT1;   route_o.bat = 2'b01; end
      4'b0101: begin route_o.conv = 1'b1; route_o.sel = SEL_BAT2;   route_o.bat = 2'b10; end
      4'b0010: begin route_o.conv = 1'b1; route_o.sel = SEL_AUX1; end
      4'b0110: begin route_o.conv = 1'b1; route_o.sel = SEL_AUX2; end
      4'b1000: route_o.drv = DRV_X;
      4'b1001: route_o.drv = DRV_Y;
      4'b1010: route_o.drv = DRV_YX;
      4'b1100: begin route_o.conv = 1'b1; route_o.sel = SEL_XP; route_o.drv = DRV_Y;  end
      4'b1101: begin route_o.conv = 1'b1; route_o.sel = SEL_YP; route_o.drv = DRV_X;  end
      4'b1110: begin route_o.conv = 1'b1; route_o.sel = SEL_XP; route_o.drv = DRV_YX; end
      4'b1111: begin route_o.conv = 1'b1; route_o.sel = SEL_YM; route_o.drv = DRV_YX; end
      default: ; // reserved: nothing switched
    endcase
  end
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic [RES_W-1:0] trial_o,
  output logic             done_o,
  output logic [RES_W-1:0] result_o
);
  localparam int unsigned DROP_W = RES_W - LOW_W;
  localparam logic [RES_W-1:0] MSB_MASK   = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [RES_W-1:0] STOP_FULL  = {{(RES_W-1){1'b0}}, 1'b1};
  localparam logic [RES_W-1:0] STOP_SHORT = STOP_FULL << DROP_W;

  logic [RES_W-1:0] acc_q, mask_q, result_q, acc_nxt, stop_mask;
  logic             busy_q, short_q, done_q;

  assign acc_nxt   = cmp_i ? (acc_q | mask_q) : acc_q;
  assign stop_mask = short_q ? STOP_SHORT : STOP_FULL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q    <= '0;
      mask_q   <= '0;
      result_q <= '0;
      busy_q   <= 1'b0;
      short_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        acc_q   <= '0;
        mask_q  <= MSB_MASK;
        short_q <= short_i;
      end else if (busy_q) begin
        acc_q  <= acc_nxt;
        mask_q <= mask_q >> 1;
        if (mask_q == stop_mask) begin
          busy_q   <= 1'b0;
          done_q   <= 1'b1;
          result_q <= short_q ? (acc_nxt >> DROP_W) : acc_nxt;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign trial_o  = busy_q ? (acc_q | mask_q) : '0;
  assign done_o   = done_q;
  assign result_o = result_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R10
  short_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && short_q) |-> ((result_q >> LOW_W) == '0));
  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && mask_q != stop_mask) |=> busy_q);
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
  import conv_seq_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned LOW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_byte_i,
  input  logic             chan_edge_i,
  input  logic             bus_end_i,
  input  logic             cmp_i,
  output logic             mux_en_o,
  output logic [SEL_W-1:0] mux_sel_o,
  output logic [DRV_W-1:0] drv_o,
  output logic             bias_lo_o,
  output logic             bias_hi_o,
  output logic [1:0]       bat_div_o,
  output logic             ref_diff_o,
  output logic             ref_on_o,
  output logic             adc_on_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  seq_state_e       state_q;
  cmd_t             cmd_q, pend_q, in_cmd, next_cmd;
  logic             pend_v_q, pend_hit;
  logic [DRV_W-1:0] hold_q;
  logic [1:0]       pwr_q;
  route_t           route;
  logic             sar_start, sar_busy, sar_done, busy, acq;

  cmd_decode i_dec (.code_i(cmd_q.code), .route_o(route));

  assign in_cmd    = unpack_cmd(cmd_byte_i);
  assign pend_hit  = pend_v_q || cmd_valid_i;
  assign next_cmd  = cmd_valid_i ? in_cmd : pend_q;
  assign acq       = (state_q == ST_ACQ);
  assign busy      = acq || (state_q == ST_CONV);
  assign sar_start = acq && bus_end_i && route.conv;

  sar_engine #(.RES_W(RES_W), .LOW_W(LOW_W)) i_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (sar_start),
    .short_i  (cmd_q.short_res),
    .cmp_i    (cmp_i),
    .busy_o   (sar_busy),
    .trial_o  (trial_o),
    .done_o   (sar_done),
    .result_o (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cmd_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      hold_q   <= '0;
      pwr_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid_i) begin
            cmd_q   <= in_cmd;
            hold_q  <= '0;
            state_q <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (cmd_valid_i) begin
            cmd_q <= in_cmd;
          end else if (chan_edge_i) begin
            state_q <= ST_ACQ;
          end else if (bus_end_i) begin
            pwr_q   <= cmd_q.pwr;
            state_q <= ST_IDLE;
          end
        end
        ST_ACQ: begin
          if (cmd_valid_i) begin
            pend_q   <= in_cmd;
            pend_v_q <= 1'b1;
          end
          if (bus_end_i) begin
            pwr_q <= cmd_q.pwr;
            if (route.conv) begin
              state_q <= ST_CONV;
            end else begin
              hold_q <= route.drv;
              if (pend_hit) begin
                cmd_q    <= next_cmd;
                pend_v_q <= 1'b0;
                hold_q   <= '0;
                state_q  <= ST_ARMED;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
        end
        ST_CONV: begin
          if (cmd_valid_i) begin
            pend_q   <= in_cmd;
            pend_v_q <= 1'b1;
          end
          if (sar_done) begin
            hold_q <= cmd_q.pwr[0] ? route.drv : '0;
            if (pend_hit) begin
              cmd_q    <= next_cmd;
              pend_v_q <= 1'b0;
              hold_q   <= '0;
              state_q  <= ST_ARMED;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mux_en_o   = acq && route.conv;
  assign mux_sel_o  = mux_en_o ? route.sel : SEL_NONE;
  assign drv_o      = busy ? route.drv : hold_q;
  assign bias_lo_o  = acq && route.bias_lo;
  assign bias_hi_o  = acq && route.bias_hi;
  assign bat_div_o  = acq ? route.bat : 2'b00;
  assign ref_diff_o = busy && route.conv && route.diff;
  assign ref_on_o   = pwr_q[1];
  assign adc_on_o   = busy || pwr_q[0];
  assign done_o     = sar_done;

  // R6
  mux_conv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sar_busy |-> !mux_en_o);
  // R7
  bias_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bias_lo_o, bias_hi_o, bat_div_o}));
  // R8
  ref_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bus_end_i) |-> $stable(ref_on_o));
  // R4
  drv_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acq && bus_end_i && !route.conv) |=> !sar_busy);
  // R8
  adc_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sar_busy |-> adc_on_o);
endmodule

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_byte = '0;
  logic        chan_edge = 1'b0;
  logic        bus_end = 1'b0;
  logic [11:0] analog = '0;
  logic        cmp;
  logic        mux_en, ref_diff, ref_on, adc_on, done, bias_lo, bias_hi;
  logic [3:0]  mux_sel, drv;
  logic [1:0]  bat_div;
  logic [11:0] trial, result;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct {int val; int due; string tag;} exp_t;
  exp_t sb[$];

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp = (trial <= analog);

  conv_sequencer i_conv_sequencer (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .chan_edge_i(chan_edge), .bus_end_i(bus_end), .cmp_i(cmp),
    .mux_en_o(mux_en), .mux_sel_o(mux_sel), .drv_o(drv), .bias_lo_o(bias_lo),
    .bias_hi_o(bias_hi), .bat_div_o(bat_div), .ref_diff_o(ref_diff),
    .ref_on_o(ref_on), .adc_on_o(adc_on), .trial_o(trial), .result_o(result),
    .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic eq(input string tag, input string what, input int act, input int exp);
    chk(act == exp, tag, what, act, exp);
  endtask

  function automatic logic [7:0] mk(input logic [3:0] code, input logic [1:0] pwr,
                                    input logic short_res, input logic spare);
    return {code, pwr, short_res, spare};
  endfunction

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_valid = 1'b1; cmd_byte = b;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic open_acq();
    @(negedge clk); chan_edge = 1'b1;
    @(negedge clk); chan_edge = 1'b0;
  endtask

  task automatic close_acq(input bit conv, input int nbits, input int val, input string tag);
    @(negedge clk); bus_end = 1'b1;
    if (conv) sb.push_back('{val, cyc + 1 + nbits, tag});
    @(negedge clk); bus_end = 1'b0;
  endtask

  task automatic settle();
    repeat (15) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        eq(e.tag, "result", int'(result), e.val);
        eq("R10", "done cycle", cyc, e.due);
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    eq("R8", "ref_on reset", ref_on, 0);
    eq("R8", "adc_on reset", adc_on, 0);
    eq("R6", "drv reset", drv, 0);
    eq("R11", "done reset", done, 0);

    // diode 0, 12-bit, power 00
    analog = 12'h5A3;
    send_cmd(mk(4'b0000, 2'b00, 1'b0, 1'b0));
    open_acq();
    eq("R2", "mux_en diode0", mux_en, 1);
    eq("R2", "sel diode0", mux_sel, 0);
    eq("R2", "ref_diff single", ref_diff, 0);
    eq("R7", "bias_lo", bias_lo, 1);
    eq("R7", "bias_hi off", bias_hi, 0);
    close_acq(1'b1, 12, 12'h5A3, "R10");
    eq("R6", "mux off in conv", mux_en, 0);
    eq("R7", "bias off in conv", bias_lo, 0);
    eq("R8", "adc on in conv", adc_on, 1);
    settle();
    eq("R8", "adc off pwr00", adc_on, 0);

    // diode 1, 8-bit, power 10
    analog = 12'hABC;
    send_cmd(mk(4'b0100, 2'b10, 1'b1, 1'b0));
    open_acq();
    eq("R2", "sel diode1", mux_sel, 1);
    eq("R7", "bias_hi", bias_hi, 1);
    eq("R8", "ref not yet latched", ref_on, 0);
    close_acq(1'b1, 8, 12'h0AB, "R10");
    eq("R8", "ref latched at end", ref_on, 1);
    settle();
    eq("R8", "ref on pwr10", ref_on, 1);
    eq("R8", "adc off pwr10", adc_on, 0);

    // battery 2, zero input, power 01
    analog = 12'h000;
    send_cmd(mk(4'b0101, 2'b01, 1'b0, 1'b0));
    open_acq();
    eq("R7", "bat2 divider", bat_div, 2'b10);
    eq("R2", "sel bat2", mux_sel, 3);
    close_acq(1'b1, 12, 0, "R10");
    settle();
    eq("R8", "adc on pwr01", adc_on, 1);
    eq("R8", "ref off pwr01", ref_on, 0);

    // aux 1, full scale
    analog = 12'hFFF;
    send_cmd(mk(4'b0010, 2'b00, 1'b0, 1'b0));
    open_acq();
    eq("R2", "sel aux1", mux_sel, 4);
    eq("R7", "no bias on aux", {bias_lo, bias_hi, bat_div}, 0);
    close_acq(1'b1, 12, 12'hFFF, "R10");
    settle();

    // X position, power 00
    analog = 12'h800;
    send_cmd(mk(4'b1100, 2'b00, 1'b0, 1'b0));
    open_acq();
    eq("R3", "X drivers", drv, 4'b0011);
    eq("R3", "sel X+", mux_sel, 6);
    eq("R3", "ref diff", ref_diff, 1);
    close_acq(1'b1, 12, 12'h800, "R3");
    eq("R6", "drivers kept in conv", drv, 4'b0011);
    eq("R6", "mux off in conv", mux_en, 0);
    settle();
    eq("R9", "drivers released pwr00", drv, 0);

    // Z2, 8-bit, power 01
    analog = 12'h0F0;
    send_cmd(mk(4'b1111, 2'b01, 1'b1, 1'b0));
    open_acq();
    eq("R3", "Z2 drivers", drv, 4'b0110);
    eq("R3", "sel Y-", mux_sel, 8);
    close_acq(1'b1, 8, 12'h00F, "R10");
    settle();
    eq("R9", "drivers held pwr01", drv, 4'b0110);

    // driver-only code 1000
    send_cmd(mk(4'b1000, 2'b00, 1'b0, 1'b0));
    eq("R9", "hold released by load", drv, 0);
    open_acq();
    eq("R4", "driver-only drivers", drv, 4'b1100);
    eq("R4", "driver-only mux", mux_en, 0);
    close_acq(1'b0, 0, 0, "R4");
    settle();
    eq("R4", "driver-only held", drv, 4'b1100);

    // reserved 1011, power 11
    send_cmd(mk(4'b1011, 2'b11, 1'b0, 1'b0));
    open_acq();
    eq("R5", "reserved drivers", drv, 0);
    eq("R5", "reserved mux", mux_en, 0);
    close_acq(1'b0, 0, 0, "R5");
    settle();
    eq("R5", "reserved no drivers after", drv, 0);
    eq("R8", "ref on pwr11", ref_on, 1);
    eq("R8", "adc on pwr11", adc_on, 1);

    // Y position with spare bit set
    analog = 12'h123;
    send_cmd(mk(4'b1101, 2'b00, 1'b0, 1'b1));
    open_acq();
    eq("R1", "spare bit sel", mux_sel, 7);
    eq("R1", "spare bit drivers", drv, 4'b1100);
    close_acq(1'b1, 12, 12'h123, "R1");
    settle();

    // pending command during conversion
    analog = 12'h456;
    send_cmd(mk(4'b1100, 2'b00, 1'b0, 1'b0));
    open_acq();
    close_acq(1'b1, 12, 12'h456, "R12");
    send_cmd(mk(4'b0110, 2'b00, 1'b1, 1'b0));
    eq("R12", "running drivers kept", drv, 4'b0011);
    eq("R12", "mux still off", mux_en, 0);
    settle();
    analog = 12'h7E0;
    open_acq();
    eq("R12", "pending sel aux2", mux_sel, 5);
    eq("R12", "pending drivers", drv, 0);
    close_acq(1'b1, 8, 12'h07E, "R12");
    settle();

    eq("R10", "scoreboard drained", sb.size(), 0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule